// File: doc/BRIEF.md
# Branch Target Buffer with Residence Footprints for Tag-Check Omission

This block sits next to the instruction fetch unit. It is a set-associative branch target buffer in which every entry carries two extra single-bit footprints. One footprint says that the instruction block starting at the branch's target is known to be in the instruction cache. The other says the same for the block starting at the branch's fall-through address. A block runs from its start address up to the next branch that already has an entry in the buffer.

On each fetch the buffer looks up the PC and returns a hit and the predicted target. It also drives a tag-omit signal that lets the instruction cache skip its tag comparison. A three-state mode machine makes that decision:

- **Normal:** tag checks are performed.
- **Trace:** a block is being watched.
- **Omit:** tag checks are skipped.

A block that runs from one buffer hit to the next with no cache miss gets its footprint recorded, at the cost of one stall cycle. Any instruction-cache miss, and any eviction of a valid buffer entry, wipes every footprint at once. An indirect jump or a branch misprediction drops the machine back to Normal. The direction prediction comes in as an input bit.

Top module: `footprint_btb`

## Requirements
- R1: After reset the mode output is Normal (encoding 0), tag_omit is low, stall is low and no lookup hits.
- R2: A valid fetch whose PC matches a stored entry raises btb_hit with that entry's target; otherwise btb_hit is low. Set index is PC bits [10:2] and tag is PC bits [31:11]. btb_target is zero when btb_hit is low.
- R3: An install request for a PC that is already stored replaces its target and clears both of its footprints. An install into a set that still has an empty way takes the lowest empty way and does not stall.
- R4: A hit in Normal or Omit mode whose selected footprint is 0 moves the mode to Trace (encoding 2). tag_omit stays low in Trace.
- R5: A fetch hit while in Trace stalls that cycle and reports no hit. It sets one footprint of the entry saved when Trace was entered: the target footprint if the saved prediction was taken, otherwise the fall-through footprint. The mode returns to Normal so that the replayed lookup is decided afresh.
- R6: On a hit, pred_taken selects the target footprint and a not-taken prediction selects the fall-through footprint. A selected footprint of 1 moves the mode to Omit (encoding 1), and tag_omit is high exactly while in Omit.
- R7: An instruction-cache miss stalls that cycle, reports no hit, clears every footprint and forces Normal.
- R8: Installing a new PC into a full set evicts the way named by a single round-robin counter. The counter starts at 0 and advances by one per eviction. The eviction behaves like R7.
- R9: An indirect jump or a misprediction forces Normal without clearing footprints and without setting one.
- R10: With no hit, no miss, no eviction and no forcing event, the mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch lookup is presented this cycle |
| fetch_pc | input | 32 | Address of the fetch |
| pred_taken | input | 1 | Direction prediction for the fetched branch |
| inst_indirect | input | 1 | An indirect jump was executed |
| mispredict | input | 1 | A branch misprediction was detected |
| icache_miss | input | 1 | The instruction cache missed |
| upd_valid | input | 1 | Install or update a branch entry |
| upd_pc | input | 32 | Branch address to install |
| upd_target | input | 32 | Target address to install |
| stall | output | 1 | Lookup held off; the fetch must replay next cycle |
| btb_hit | output | 1 | Lookup hit |
| btb_target | output | 32 | Predicted target on a hit |
| tag_omit | output | 1 | The instruction cache may skip its tag check |
| mode_o | output | 2 | Current mode: 0 Normal, 1 Omit, 2 Trace |

## Verification
A footprint that is wrongly set, cleared or aimed at the wrong entry does not show up when it is written. It shows up at the next hit on the affected entry, one cycle later on mode_o and tag_omit. A wrongly cleared footprint shows as Trace where Omit is due. A stale one shows as Omit after a miss or eviction, which is the dangerous case.

A wrong previous-branch pointer shows up only after a later replay on the corrupted entry. The random phase keeps a few sets busy so that such replays happen within tens of cycles.

A lost or extra stall is visible in the same cycle as a btb_hit mismatch.

// File: rtl/fpo_pkg.sv
package fpo_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_OMIT   = 2'd1,
    MODE_TRACE  = 2'd2
  } mode_e;

  // Footprint picked by the predicted direction.
  function automatic logic pick_flag(input logic taken, input logic ft, input logic ff);
    return taken ? ft : ff;
  endfunction

  // Mode transition: forced returns and writes first, then a fresh hit, else hold.
  function automatic mode_e next_mode(input mode_e cur, input logic to_normal,
                                      input logic wrote, input logic hit, input logic sel);
    if (to_normal || wrote) return MODE_NORMAL;
    if (hit) return sel ? MODE_OMIT : MODE_TRACE;
    return cur;
  endfunction

endpackage

// File: rtl/fpo_btb_store.sv
module fpo_btb_store #(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int PC_W  = 32,
  parameter int OFF_W = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = PC_W - IDX_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_set,
  output logic [WAY_W-1:0] lk_way,
  output logic [PC_W-1:0]  lk_target,
  output logic             lk_ft,
  output logic             lk_ff,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [PC_W-1:0]  upd_target,
  output logic             upd_evict,
  input  logic             fp_wr,
  input  logic [IDX_W-1:0] fp_set,
  input  logic [WAY_W-1:0] fp_way,
  input  logic             fp_taken,
  input  logic             flush
);

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] pc);
    return pc[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  ft_q    [SETS];
  logic [WAYS-1:0]  ff_q    [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PC_W-1:0]  tgt_q   [SETS][WAYS];
  logic [WAY_W-1:0] rr_q;

  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [IDX_W-1:0] up_set;
  logic [WAYS-1:0]  lk_match, up_match;
  logic             up_hit, up_free_ok;
  logic [WAY_W-1:0] up_way, up_free_way, alloc_way;

  assign lk_set = set_of(lk_pc);
  assign lk_tag = tag_of(lk_pc);
  assign up_set = set_of(upd_pc);
  assign up_tag = tag_of(upd_pc);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign lk_match[g] = valid_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
    assign up_match[g] = valid_q[up_set][g] && (tag_q[up_set][g] == up_tag);
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    up_hit = 1'b0;
    up_way = '0;
    up_free_ok = 1'b0;
    up_free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w] && !lk_hit) begin
        lk_hit = 1'b1;
        lk_way = w[WAY_W-1:0];
      end
      if (up_match[w] && !up_hit) begin
        up_hit = 1'b1;
        up_way = w[WAY_W-1:0];
      end
      if (!valid_q[up_set][w] && !up_free_ok) begin
        up_free_ok = 1'b1;
        up_free_way = w[WAY_W-1:0];
      end
    end
  end

  assign alloc_way = up_hit ? up_way : (up_free_ok ? up_free_way : rr_q);
  assign upd_evict = upd_valid && !up_hit && !up_free_ok;
  assign lk_target = tgt_q[lk_set][lk_way];
  assign lk_ft     = ft_q[lk_set][lk_way];
  assign lk_ff     = ff_q[lk_set][lk_way];

  // Valid bits, footprints and victim pointer (reset state).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ft_q[s]    <= '0;
        ff_q[s]    <= '0;
      end
      rr_q <= '0;
    end else begin
      if (fp_wr) begin
        if (fp_taken) ft_q[fp_set][fp_way] <= 1'b1;
        else          ff_q[fp_set][fp_way] <= 1'b1;
      end
      if (upd_valid) begin
        valid_q[up_set][alloc_way] <= 1'b1;
        ft_q[up_set][alloc_way]    <= 1'b0;
        ff_q[up_set][alloc_way]    <= 1'b0;
        if (upd_evict)
          rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
      end
      if (flush) begin
        for (int s = 0; s < SETS; s++) begin
          ft_q[s] <= '0;
          ff_q[s] <= '0;
        end
      end
    end
  end

  // Tag and target storage (array, no reset).
  always_ff @(posedge clk) begin
    if (upd_valid) begin
      tag_q[up_set][alloc_way] <= up_tag;
      tgt_q[up_set][alloc_way] <= upd_target;
    end
  end

endmodule

// File: rtl/fpo_mode_ctrl.sv
module fpo_mode_ctrl
  import fpo_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             raw_hit,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             pred_taken,
  input  logic             lk_ft,
  input  logic             lk_ff,
  input  logic             flush,
  input  logic             force_nrm,
  output mode_e            mode_q,
  output logic             hit_ok,
  output logic             fp_wr,
  output logic [IDX_W-1:0] fp_set,
  output logic [WAY_W-1:0] fp_way,
  output logic             fp_taken
);

  logic  sel;
  mode_e mode_d;

  assign fp_wr  = fetch_valid && raw_hit && (mode_q == MODE_TRACE) && !flush && !force_nrm;
  assign hit_ok = fetch_valid && raw_hit && !flush && !fp_wr;
  assign sel    = pick_flag(pred_taken, lk_ft, lk_ff);
  assign mode_d = next_mode(mode_q, flush || force_nrm, fp_wr, hit_ok, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_NORMAL;
      fp_set   <= '0;
      fp_way   <= '0;
      fp_taken <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (hit_ok && !force_nrm && !sel) begin
        fp_set   <= lk_set;
        fp_way   <= lk_way;
        fp_taken <= pred_taken;
      end
    end
  end

endmodule

// File: rtl/footprint_btb.sv
module footprint_btb
  import fpo_pkg::*;
#(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int PC_W  = 32,
  parameter int OFF_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            pred_taken,
  input  logic            inst_indirect,
  input  logic            mispredict,
  input  logic            icache_miss,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  output logic            stall,
  output logic            btb_hit,
  output logic [PC_W-1:0] btb_target,
  output logic            tag_omit,
  output logic [1:0]      mode_o
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic             raw_hit, lk_ft, lk_ff, store_evict, flush, force_nrm;
  logic             hit_ok, fp_wr, fp_taken;
  logic [IDX_W-1:0] lk_set, fp_set;
  logic [WAY_W-1:0] lk_way, fp_way;
  logic [PC_W-1:0]  lk_target;
  mode_e            mode_q;

  assign flush     = icache_miss || store_evict;
  assign force_nrm = inst_indirect || mispredict;

  fpo_btb_store #(.SETS(SETS), .WAYS(WAYS), .PC_W(PC_W), .OFF_W(OFF_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(fetch_pc), .lk_hit(raw_hit), .lk_set(lk_set), .lk_way(lk_way),
    .lk_target(lk_target), .lk_ft(lk_ft), .lk_ff(lk_ff),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_evict(store_evict),
    .fp_wr(fp_wr), .fp_set(fp_set), .fp_way(fp_way), .fp_taken(fp_taken), .flush(flush)
  );

  fpo_mode_ctrl #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .raw_hit(raw_hit), .lk_set(lk_set), .lk_way(lk_way),
    .pred_taken(pred_taken), .lk_ft(lk_ft), .lk_ff(lk_ff),
    .flush(flush), .force_nrm(force_nrm),
    .mode_q(mode_q), .hit_ok(hit_ok),
    .fp_wr(fp_wr), .fp_set(fp_set), .fp_way(fp_way), .fp_taken(fp_taken)
  );

  assign stall      = flush || fp_wr;
  assign btb_hit    = hit_ok;
  assign btb_target = hit_ok ? lk_target : '0;
  assign tag_omit   = (mode_q == MODE_OMIT);
  assign mode_o     = mode_q;

endmodule

// File: rtl/fpo_checker.sv
module fpo_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_valid,
  input logic       inst_indirect,
  input logic       mispredict,
  input logic       icache_miss,
  input logic       store_evict,
  input logic       raw_hit,
  input logic       fp_wr,
  input logic       stall,
  input logic       btb_hit,
  input logic       tag_omit,
  input logic [1:0] mode_o
);

  // R2: the mode register never holds the unused code
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n) mode_o != 2'd3);

  // R7: a stalled cycle reports no hit
  a_r7_stall_no_hit: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !btb_hit);

  // R7: a cache miss leaves Normal mode with tag checks on
  a_r7_miss_normal: assert property (@(posedge clk) disable iff (!rst_n)
    icache_miss |=> (mode_o == 2'd0 && !tag_omit));

  // R8: an eviction stalls and returns to Normal
  a_r8_evict_normal: assert property (@(posedge clk) disable iff (!rst_n)
    store_evict |-> stall ##1 (mode_o == 2'd0));

  // R9: indirect jumps and mispredictions force Normal
  a_r9_force_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_indirect || mispredict) |=> mode_o == 2'd0);

  // R5: a hit in Trace stalls and is followed by Normal
  a_r5_trace_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && fetch_valid && raw_hit && !icache_miss && !store_evict
     && !inst_indirect && !mispredict) |-> (fp_wr && stall) ##1 (mode_o == 2'd0));

  // R6: an accepted hit lands in Omit or Trace
  a_r6_hit_decides: assert property (@(posedge clk) disable iff (!rst_n)
    (btb_hit && !inst_indirect && !mispredict) |=> mode_o != 2'd0);

  // R10: a quiet cycle holds the mode
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !icache_miss && !store_evict && !inst_indirect && !mispredict)
      |=> $stable(mode_o));

endmodule

bind footprint_btb fpo_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .inst_indirect(inst_indirect),
  .mispredict(mispredict), .icache_miss(icache_miss), .store_evict(store_evict),
  .raw_hit(raw_hit), .fp_wr(fp_wr), .stall(stall), .btb_hit(btb_hit),
  .tag_omit(tag_omit), .mode_o(mode_o)
);

// File: tb/tb_footprint_btb.sv
module tb_footprint_btb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 0, pred_taken = 0, inst_indirect = 0, mispredict = 0;
  logic        icache_miss = 0, upd_valid = 0;
  logic [31:0] fetch_pc = 0, upd_pc = 0, upd_target = 0;
  logic        stall, btb_hit, tag_omit;
  logic [31:0] btb_target;
  logic [1:0]  mode_o;

  always #10 clk = ~clk;  // 50 MHz

  footprint_btb dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .inst_indirect(inst_indirect), .mispredict(mispredict),
    .icache_miss(icache_miss), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target), .stall(stall), .btb_hit(btb_hit), .btb_target(btb_target),
    .tag_omit(tag_omit), .mode_o(mode_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference state built from the requirements
  bit          mv  [512][4];
  bit          mft [512][4];
  bit          mff [512][4];
  logic [20:0] mtag[512][4];
  logic [31:0] mtgt[512][4];
  int          mmode = 0;
  int          p_set = 0, p_way = 0, rr = 0;
  bit          p_tk = 0;

  function automatic logic [31:0] mk(input int tag, input int set);
    return (32'(tag) << 11) | (32'(set) << 2);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [31:0] pc, input bit pt, input bit ind,
                      input bit mis, input bit miss, input bit uv, input logic [31:0] upc,
                      input logic [31:0] utg, input string req);
    int  s, us, way, uway, fway;
    bit  hit, umatch, ffree, evict, flush, frc, fw, e_stall, e_hit, sel;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; pred_taken = pt; inst_indirect = ind;
    mispredict = mis; icache_miss = miss; upd_valid = uv; upd_pc = upc; upd_target = utg;
    #1;
    s = int'(pc[10:2]); us = int'(upc[10:2]);
    hit = 0; way = 0; umatch = 0; uway = 0; ffree = 0; fway = 0;
    for (int w = 0; w < 4; w++) begin
      if (!hit && mv[s][w] && mtag[s][w] == pc[31:11]) begin hit = 1; way = w; end
      if (!umatch && mv[us][w] && mtag[us][w] == upc[31:11]) begin umatch = 1; uway = w; end
      if (!ffree && !mv[us][w]) begin ffree = 1; fway = w; end
    end
    evict   = uv && !umatch && !ffree;
    flush   = miss || evict;
    frc     = ind || mis;
    fw      = fv && hit && mmode == 2 && !flush && !frc;
    e_stall = flush || fw;
    e_hit   = fv && hit && !e_stall;
    chk(req, "stall", 32'(stall), 32'(e_stall));
    chk(req, "btb_hit", 32'(btb_hit), 32'(e_hit));
    chk(req, "btb_target", btb_target, e_hit ? mtgt[s][way] : 32'd0);
    chk(req, "tag_omit", 32'(tag_omit), 32'(mmode == 1));
    chk(req, "mode", 32'(mode_o), 32'(mmode));
    sel = pt ? mft[s][way] : mff[s][way];
    if (fw) begin
      if (p_tk) mft[p_set][p_way] = 1; else mff[p_set][p_way] = 1;
    end
    if (uv) begin
      if (!umatch) uway = ffree ? fway : rr;
      mv[us][uway] = 1; mtag[us][uway] = upc[31:11]; mtgt[us][uway] = utg;
      mft[us][uway] = 0; mff[us][uway] = 0;
      if (evict) rr = (rr + 1) % 4;
    end
    if (flush)
      for (int a = 0; a < 512; a++)
        for (int b = 0; b < 4; b++) begin mft[a][b] = 0; mff[a][b] = 0; end
    if (flush || frc || fw) mmode = 0;
    else if (e_hit) begin
      if (sel) mmode = 1;
      else begin mmode = 2; p_set = s; p_way = way; p_tk = pt; end
    end
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic fetch(input logic [31:0] pc, input bit pt, input string req);
    step(1, pc, pt, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic inst(input logic [31:0] pc, input logic [31:0] tg, input string req);
    step(0, 0, 0, 0, 0, 0, 1, pc, tg, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb, pc_c, pd, pe;
    int r;
    pa = mk(1, 5); pb = mk(2, 5); pc_c = mk(3, 5); pd = mk(4, 5); pe = mk(5, 5);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty buffer, Normal mode
    fetch(pa, 1, "R1");
    // R3: install into a free way, no stall; R2: hit returns target
    inst(pa, 32'h0000_1000, "R3");
    fetch(pb, 1, "R2");
    fetch(pa, 1, "R2");               // flag 0 -> Trace (R4)
    idle("R4");
    fetch(pa, 1, "R5");               // write target flag, stall
    fetch(pa, 1, "R6");               // replay -> Omit
    idle("R6");
    fetch(pa, 0, "R6");               // fall-through flag still 0 -> Trace
    inst(pb, 32'h0000_2000, "R3");
    fetch(pb, 0, "R5");               // set fall-through flag of pa
    fetch(pb, 0, "R4");               // replay: pb flag 0 -> Trace
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");  // misprediction
    fetch(pa, 0, "R9");               // flag kept -> Omit
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R9");  // indirect jump
    idle("R10");
    inst(pa, 32'h0000_3000, "R3");    // retarget clears flags of pa
    fetch(pa, 1, "R3");
    idle("R10");
    fetch(pa, 1, "R5");
    fetch(pa, 1, "R6");
    step(1, pa, 1, 0, 0, 1, 0, 0, 0, "R7");  // cache miss
    fetch(pa, 1, "R7");               // flags gone -> Trace
    inst(pc_c, 32'h0000_4000, "R8");
    inst(pd, 32'h0000_5000, "R8");
    inst(pe, 32'h0000_6000, "R8");    // evicts way 0 (pa)
    fetch(pa, 1, "R8");
    fetch(pe, 1, "R8");
    idle("R10");
    // Random phase
    r = $urandom(32'd2024);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p, u;
      p = mk(1 + $urandom % 6, ($urandom % 2) ? 5 : 9);
      u = mk(1 + $urandom % 6, ($urandom % 2) ? 5 : 9);
      step(($urandom % 10) < 7, p, $urandom % 2, ($urandom % 40) == 0, ($urandom % 40) == 0,
           ($urandom % 40) == 0, ($urandom % 12) == 0, u, $urandom, "R2");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule